// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block burns one word of a one-time-programmable fuse array. A request carries a word address, a 32-bit program value and a packed timing value. When the request is accepted, the sequencer reads the current contents of the target word. It masks the program value with that read, so a bit that is already blown is never driven a second time. The masked value goes into an internal data register. That register is then walked one bit per step, shifting right with zero fill.

Each bit position whose low bit is 1 gets a full blow sequence: a relax gap, a strobe pulse, and a second relax gap. A bit position with a 0 costs a single shift cycle. Once all 32 positions are handled, BUSY drops and a one-cycle done pulse is raised. A quiet interval of a parameterised number of clocks follows, and no new request is taken during it.

The fuse array is modelled inside the block as a register file. Its only write path sets one bit at a time, at the end of each strobe pulse. A separate read port lets the surrounding logic observe any word.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset, busy, done and strobe are 0, ready is 1, and every fuse word reads 0.
- R2: On acceptance, the data register is loaded with the program value AND NOT the current fuse word. After the operation, the word reads as the OR of its old contents and the program value, so programming a word twice leaves the OR of both values.
- R3: Exactly one strobe pulse is issued per 1 bit of the masked value. A 0 bit produces no pulse and leaves its fuse bit unchanged.
- R4: Each strobe pulse is high for exactly timing[11:0] consecutive cycles. A value of 0 is treated as 1.
- R5: The relax width is timing[15:12] cycles, with 0 treated as 1. Busy stays high for exactly 32 + k*(2*relax + strobe) cycles, where k is the number of 1 bits in the masked value.
- R6: While busy, the data register only shifts right with zero fill, and it is 0 at the end. A request presented while busy is ignored and changes no fuse word.
- R7: Done is high for exactly one cycle: the first cycle in which busy is low after an operation.
- R8: From the cycle in which busy falls, ready stays low for exactly QUIET_CYC cycles. A request presented in that window is ignored.
- R9: A request with start high while ready is high makes busy high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while ready is high |
| addr | input | ADDR_W | Target fuse word |
| wdata | input | DATA_W | Program value, where a 1 means blow that bit |
| timing | input | STRB_W+RLX_W | [11:0] strobe width, [15:12] relax width, both in clocks |
| ready | output | 1 | Idle, so a new request can be accepted |
| busy | output | 1 | Programming in progress |
| done | output | 1 | One-cycle completion pulse |
| strobe | output | 1 | Program strobe to the fuse cell |
| shift_data | output | DATA_W | Current contents of the serial data register |
| rd_addr | input | ADDR_W | Read port word address |
| rd_data | output | DATA_W | Read port data, combinational |

## Verification
A wrong bit counter or a bad mask shows up at the ports during the operation itself. It appears as a wrong number of strobe pulses, and the busy length moves by 2*relax+strobe cycles for each extra or missing pulse. A wrong fuse bit appears on the read port as soon as busy drops. A miscounted delay shows as a strobe pulse width or a quiet window that is off by cycles, and this is visible within a single operation. A request that leaks through while busy or quiet shows either as busy rising in the next cycle or as stray blown bits in the read-back.

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq #(
  parameter int WORDS     = 64,
  parameter int DATA_W    = 32,
  parameter int STRB_W    = 12,
  parameter int RLX_W     = 4,
  parameter int QUIET_CYC = 200
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(WORDS)-1:0]  addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [STRB_W+RLX_W-1:0]   timing,
  output logic                      ready,
  output logic                      busy,
  output logic                      done,
  output logic                      strobe,
  output logic [DATA_W-1:0]         shift_data,
  input  logic [$clog2(WORDS)-1:0]  rd_addr,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int ADDR_W = $clog2(WORDS);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int TIM_W  = STRB_W + RLX_W;
  localparam int CNT_W  = (STRB_W > RLX_W) ? STRB_W : RLX_W;
  localparam int Q_W    = $clog2(QUIET_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_EXAM, S_RLX1, S_STRB, S_RLX2, S_QUIET} st_t;

  st_t                st_q;
  logic [DATA_W-1:0]  data_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [TIM_W-1:0]   tim_q;
  logic [BIT_W-1:0]   bit_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [Q_W-1:0]     qcnt_q;
  logic               done_q;
  logic [DATA_W-1:0]  fuse_q [WORDS];

  logic [RLX_W-1:0]   rlx_f;
  logic [STRB_W-1:0]  stb_f;
  logic [CNT_W-1:0]   rlx_ld, stb_ld;
  logic               accept, last_bit, blow;

  assign rlx_f    = tim_q[TIM_W-1:STRB_W];
  assign stb_f    = tim_q[STRB_W-1:0];
  assign rlx_ld   = (rlx_f == '0) ? '0 : CNT_W'(rlx_f - 1'b1);
  assign stb_ld   = (stb_f == '0) ? '0 : CNT_W'(stb_f - 1'b1);
  assign last_bit = (bit_q == BIT_W'(DATA_W - 1));
  assign accept   = start && (st_q == S_IDLE);
  assign blow     = (st_q == S_STRB) && (cnt_q == '0);

  assign ready      = (st_q == S_IDLE);
  assign busy       = (st_q != S_IDLE) && (st_q != S_QUIET);
  assign strobe     = (st_q == S_STRB);
  assign done       = done_q;
  assign shift_data = data_q;
  assign rd_data    = fuse_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      data_q <= '0;
      addr_q <= '0;
      tim_q  <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      qcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          data_q <= wdata & ~fuse_q[addr];
          addr_q <= addr;
          tim_q  <= timing;
          bit_q  <= '0;
          st_q   <= S_EXAM;
        end
        S_EXAM: begin
          if (data_q[0]) begin
            cnt_q <= rlx_ld;
            st_q  <= S_RLX1;
          end else begin
            data_q <= data_q >> 1;
            if (last_bit) begin
              st_q   <= S_QUIET;
              qcnt_q <= Q_W'(QUIET_CYC - 1);
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        S_RLX1: begin
          if (cnt_q == '0) begin
            cnt_q <= stb_ld;
            st_q  <= S_STRB;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_STRB: begin
          if (cnt_q == '0) begin
            cnt_q <= rlx_ld;
            st_q  <= S_RLX2;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_RLX2: begin
          if (cnt_q == '0) begin
            data_q <= data_q >> 1;
            if (last_bit) begin
              st_q   <= S_QUIET;
              qcnt_q <= Q_W'(QUIET_CYC - 1);
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              st_q  <= S_EXAM;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_QUIET: begin
          if (qcnt_q == '0) st_q <= S_IDLE;
          else qcnt_q <= qcnt_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) fuse_q[i] <= '0;
    end else if (blow) begin
      fuse_q[addr_q][bit_q] <= 1'b1;
    end
  end

  p_strobe_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> busy);

  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_shift_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(shift_data)) |-> (shift_data == ($past(shift_data) >> 1)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!busy && !strobe && !done));

  p_fuse_stable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

// File: tb/fuse_burn_seq_tb.sv
module fuse_burn_seq_tb;
  localparam int CLK_P  = 10;
  localparam int QUIET  = 24;
  localparam int WORDS  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] timing = '0;
  logic        ready, busy, done, strobe;
  logic [31:0] shift_data;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_mem [WORDS];

  always #(CLK_P/2) clk = ~clk;

  fuse_burn_seq #(.WORDS(WORDS), .QUIET_CYC(QUIET)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wdata(wdata),
    .timing(timing), .ready(ready), .busy(busy), .done(done), .strobe(strobe),
    .shift_data(shift_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic burn(input logic [5:0] a, input logic [31:0] d, input logic [15:0] tim,
                      input bit poke);
    logic [31:0] old, masked, other_old;
    int k, s, r, busy_n, pulses, badw, run, q, dcnt;
    old = exp_mem[a];
    other_old = exp_mem[a ^ 6'd1];
    masked = d & ~old;
    k = $countones(masked);
    s = eff(int'(tim[11:0]));
    r = eff(int'(tim[15:12]));
    @(negedge clk);
    chk(ready, "R9 ready before request", ready, 1);
    addr = a; wdata = d; timing = tim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after accept", busy, 1);
    chk(shift_data == masked, "R2 masked load", shift_data, masked);
    busy_n = 0; pulses = 0; badw = 0; run = 0;
    while (busy) begin
      busy_n++;
      if (strobe) run++;
      else if (run > 0) begin
        pulses++;
        if (run != s) badw++;
        run = 0;
      end
      if (poke && busy_n == 5) begin
        start = 1'b1; wdata = ~d; addr = a ^ 6'd1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    if (run > 0) begin pulses++; if (run != s) badw++; end
    chk(busy_n == 32 + k*(2*r + s), "R5 busy length", busy_n, 32 + k*(2*r + s));
    chk(pulses == k, "R3 pulse count", pulses, k);
    chk(badw == 0, "R4 strobe width", badw, 0);
    chk(done, "R7 done on busy fall", done, 1);
    chk(shift_data == 0, "R6 data drained", shift_data, 0);
    q = 0; dcnt = 0;
    start = 1'b1; wdata = 32'hFFFF_FFFF; addr = a;
    while (!ready && q < QUIET + 10) begin
      q++;
      if (done) dcnt++;
      @(negedge clk);
      start = 1'b0;
      if (busy) chk(0, "R8 request taken in quiet", busy, 0);
    end
    start = 1'b0;
    chk(q == QUIET, "R8 quiet length", q, QUIET);
    chk(dcnt == 1, "R7 done single cycle", dcnt, 1);
    exp_mem[a] = old | d;
    rd_addr = a;
    #1;
    chk(rd_data == exp_mem[a], "R2 fuse read-back OR", rd_data, exp_mem[a]);
    if (poke) begin
      rd_addr = a ^ 6'd1;
      #1;
      chk(rd_data == other_old, "R6 request while busy ignored", rd_data, other_old);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !strobe && ready, "R1 reset outputs",
        {busy, done, strobe, ready}, 4'b0001);
    rst_n = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < WORDS; i++) begin
        rd_addr = 6'(i); #1;
        if (rd_data != 0) bad++;
      end
      chk(bad == 0, "R1 fuse array clear", bad, 0);
    end
    // R2 R3 twice-programmed word ends as OR
    burn(6'd3, 32'hA5A5_00F1, 16'h2005, 1'b0);
    burn(6'd3, 32'h0F0F_FF11, 16'h2005, 1'b0);
    // R3 zero data: no pulses
    burn(6'd7, 32'h0, 16'h1003, 1'b0);
    // R4 R5 zero widths treated as one
    burn(6'd8, 32'h8000_0001, 16'h0000, 1'b0);
    // R4 long strobe, all ones, poke while busy (R6)
    burn(6'd10, 32'hFFFF_FFFF, 16'hF12C, 1'b1);
    // R2 fully blown word: nothing new to program
    burn(6'd10, 32'h1234_5678, 16'h3004, 1'b0);
    for (int t = 0; t < 20; t++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic [15:0] tm;
      a  = 6'($urandom_range(0, WORDS-1));
      d  = $urandom() & $urandom();
      tm = {4'($urandom_range(0, 6)), 12'($urandom_range(0, 20))};
      burn(a, d, tm, t[2]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule